// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire PHY management bus (MDC clock and MDIO data) of an Ethernet port. It runs exactly one clause 22 transaction per accepted request: a read returns one 16-bit PHY register, and a write stores one. Each transaction begins with a preamble of ones on the line, then the command header and, for a write, the data. For a read, the line is released and the PHY's answer is captured. MDC is produced by a parameterised divider of the system clock. Data is changed only while MDC is low and is sampled just before MDC rises.

Requests arrive on a valid/ready channel. `req_ready` is high only while the master is idle. A request is taken in the cycle where both `req_valid` and `req_ready` are high. While a transaction runs, `req_ready` stays low and anything on the request pins is ignored. A read answer is returned on a valid/ready response channel. `rsp_valid` and `rsp_rdata` hold steady until `rsp_ready` is seen, and the master stays busy until then, so a slow consumer stalls further requests instead of losing data. Writes give no response. A register address outside 0..31 never reaches the bus. A read of that kind answers 0xFFFF in the next cycle, and a write of that kind is simply dropped. The busy flag is bit 31 of a 32-bit status word.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` and `mdio_oe` are 0, `req_ready` is 1, `rsp_valid` is 0 and `status` is 0.
- R2: Each MDC high phase and each low phase inside a transaction lasts exactly HALF_DIV system clocks. With the default of 50 at a 4 ns clock, the MDC period is 400 ns and never shorter. MDC rests low when idle.
- R3: Every transaction with a valid address starts with 33 MDC periods in which MDIO is driven (`mdio_oe`=1) to 1. A read makes 68 rising MDC edges in all; a write makes 67.
- R4: After the preamble, a read drives 16 bits, MSB first, one per MDC period: 1,1,0,1,1,0, then `req_phy[4:0]`, then `req_reg[4:0]`.
- R5: After the read header, `mdio_oe` is 0 for 19 MDC periods, and `mdio_i` is sampled once per period before the rising edge. The samples are numbered 0 to 18. The response is samples 2 to 17, with sample 2 as bit 15. Samples 0, 1 and 18 are dropped.
- R6: After the preamble, a write drives 32 bits, MSB first: 0,1,0,1, `req_phy[4:0]`, `req_reg[4:0]`, 1,0, then `req_wdata[15:0]`. It then releases MDIO for 2 more MDC periods and gives no response.
- R7: `mdio_o` and `mdio_oe` do not change while MDC is high.
- R8: `req_reg` is REG_AW bits wide and is valid only when its value is 0..31. For an invalid address, MDC stays low. A read then gives `rsp_valid` with 0xFFFF in the cycle after acceptance. A write returns to idle (status bit 31 = 0) in that same cycle.
- R9: `status[31]` is 1 from the cycle after acceptance until the transaction completes. A write completes at the end of its last idle period; a read completes when its response is taken. `status[30:16]` is 0, and `status[15:0]` holds the last read response.
- R10: A request is accepted only while `req_ready` is 1. `req_valid` asserted during a transaction changes neither the bus activity nor the result, and starts nothing later.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_rdata` stays stable. The cycle after `rsp_ready` is seen, `rsp_valid` and `status[31]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_AW | Register address (valid 0..31) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 16 | Read response data |
| status | output | 32 | Bit 31 busy, bits 15:0 last read result |
| mdc | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from pad |

## Verification
A wrong bit counter or a wrong segment state shows at the pins within one MDC period. The preamble, header or released window then has the wrong length, and a PHY model that records each rising edge sees a wrong bit position or a wrong edge count. A wrong divider count changes the MDC half period on its first toggle. A capture that is off by one sample gives read data shifted by one bit, which the known register values expose at once. A busy or response state that is left set or cleared too early shows in the next cycle as a wrong `req_ready`, `rsp_valid` or status bit 31.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW      = 5;
  localparam int DATA_W      = 16;
  localparam int FRAME_W     = 32;
  localparam int PRE_BITS    = 33;
  localparam int RD_HDR_BITS = 16;
  localparam int WR_HDR_BITS = 32;
  localparam int CAPT_BITS   = 19;
  localparam int CAPT_FIRST  = 2;   // first data sample index in capture window
  localparam int TAIL_BITS   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_CMD, ST_CAPT, ST_TAIL, ST_RESP
  } mdio_state_e;

  // Header left-aligned in a 32-bit word, first bit on the wire in bit 31.
  function automatic logic [FRAME_W-1:0] header_word(
    input logic              wr,
    input logic [PHY_AW-1:0] phy,
    input logic [PHY_AW-1:0] ra,
    input logic [DATA_W-1:0] wd
  );
    if (wr) return {2'b01, 2'b01, phy, ra, 2'b10, wd};
    else    return {2'b11, 2'b01, 2'b10, phy, ra, 16'h0000};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap     = run && (cnt_q == CNT_LAST);
  assign rise_evt = wrap && !mdc_q;
  assign fall_evt = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shift_out.sv
module mdio_shift_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q;

  assign msb = sr_q[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mdio_shift_in.sv
module mdio_shift_in #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] sr_q;

  assign word = sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sr_q <= '0;
    else if (shift)      sr_q <= {sr_q[W-2:0], din};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 50,
  parameter int REG_AW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata,
  output logic [31:0]       status,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int BIT_CW = $clog2(PRE_BITS);
  localparam logic [BIT_CW-1:0] LAST_PRE  = BIT_CW'(PRE_BITS - 1);
  localparam logic [BIT_CW-1:0] LAST_RHDR = BIT_CW'(RD_HDR_BITS - 1);
  localparam logic [BIT_CW-1:0] LAST_WHDR = BIT_CW'(WR_HDR_BITS - 1);
  localparam logic [BIT_CW-1:0] LAST_CAPT = BIT_CW'(CAPT_BITS - 1);
  localparam logic [BIT_CW-1:0] LAST_TAIL = BIT_CW'(TAIL_BITS - 1);
  localparam logic [BIT_CW-1:0] DAT_LO    = BIT_CW'(CAPT_FIRST);
  localparam logic [BIT_CW-1:0] DAT_HI    = BIT_CW'(CAPT_FIRST + DATA_W - 1);

  mdio_state_e       state_q;
  logic [BIT_CW-1:0] bit_q;
  logic [BIT_CW-1:0] seg_last;
  logic              is_wr_q;
  logic [15:0]       rsp_q;
  logic              reg_ok;
  logic              accept;
  logic              run;
  logic              rise_evt, fall_evt;
  logic              tx_msb;
  logic [15:0]       rx_word;
  logic [1:0]        mdi_sync_q;
  logic              cap_shift;

  // Register address is valid only within the 5-bit clause 22 range.
  assign reg_ok = ((req_reg >> 5) == '0);
  assign accept = (state_q == ST_IDLE) && req_valid;
  assign run    = (state_q == ST_PRE) || (state_q == ST_CMD) ||
                  (state_q == ST_CAPT) || (state_q == ST_TAIL);

  always_comb begin
    unique case (state_q)
      ST_PRE:  seg_last = LAST_PRE;
      ST_CMD:  seg_last = is_wr_q ? LAST_WHDR : LAST_RHDR;
      ST_CAPT: seg_last = LAST_CAPT;
      ST_TAIL: seg_last = LAST_TAIL;
      default: seg_last = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mdi_sync_q <= 2'b11;
    else        mdi_sync_q <= {mdi_sync_q[0], mdio_i};
  end

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_shift_out #(.W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(accept && reg_ok),
    .load_val(header_word(req_write, req_phy, req_reg[4:0], req_wdata)),
    .shift((state_q == ST_CMD) && fall_evt),
    .msb(tx_msb)
  );

  // Only the data samples of the capture window are kept.
  assign cap_shift = (state_q == ST_CAPT) && rise_evt &&
                     (bit_q >= DAT_LO) && (bit_q <= DAT_HI);

  mdio_shift_in #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .clear(accept), .shift(cap_shift),
    .din(mdi_sync_q[1]), .word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      is_wr_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            bit_q   <= '0;
            is_wr_q <= req_write;
            if (reg_ok) begin
              state_q <= ST_PRE;
            end else if (!req_write) begin
              state_q <= ST_RESP;
              rsp_q   <= 16'hFFFF;
            end
          end
        end
        ST_PRE, ST_CMD, ST_CAPT, ST_TAIL: begin
          if (fall_evt) begin
            if (bit_q == seg_last) begin
              bit_q <= '0;
              unique case (state_q)
                ST_PRE:  state_q <= ST_CMD;
                ST_CMD:  state_q <= is_wr_q ? ST_TAIL : ST_CAPT;
                ST_CAPT: begin
                  state_q <= ST_RESP;
                  rsp_q   <= rx_word;
                end
                default: state_q <= ST_IDLE;
              endcase
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rsp_q;
  assign status    = {(state_q != ST_IDLE), 15'h0000, rsp_q};
  assign mdio_oe   = (state_q == ST_PRE) || (state_q == ST_CMD);
  assign mdio_o    = (state_q == ST_CMD) ? tx_msb : 1'b1;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 50,
  parameter int REG_AW   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [REG_AW-1:0] req_reg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [15:0]       rsp_rdata,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  logic        mdc_prev;
  logic [15:0] hold;
  logic        ok_addr;

  assign ok_addr = ((req_reg >> 5) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_prev <= 1'b0;
      hold     <= 16'hFFFF;
    end else begin
      mdc_prev <= mdc;
      if (mdc != mdc_prev)     hold <= 16'd1;
      else if (hold != 16'hFFFF) hold <= hold + 16'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_prev) |-> (hold >= 16'(HALF_DIV)));

  assert_stable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && mdc_prev) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_oe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !ok_addr) |=>
      (rsp_valid && rsp_rdata == 16'hFFFF));

  assert_bad_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !ok_addr) |=> (!busy && !mdc));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ok_addr) |=> busy);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_reg(req_reg), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .busy(status[31]),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = 50;
  localparam int RAW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_write = 1'b0;
  logic [4:0]     req_phy = '0;
  logic [RAW-1:0] req_reg = '0;
  logic [15:0]    req_wdata = '0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b1;
  logic [15:0]    rsp_rdata;
  logic [31:0]    status;
  logic           mdc, mdio_o, mdio_oe;
  logic           mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF), .REG_AW(RAW)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .status(status), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int      checks = 0, fails = 0, cycles = 0, r7_bad = 0;
  int      nrise = 0;
  int      rec [0:127];
  realtime last_rise = 0.0, min_period = 1.0e9, min_hi = 1.0e9, max_hi = 0.0;
  logic    rd_on = 1'b0;
  logic [15:0] rd_val = '0;

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return {r, p, 6'b101101} ^ 16'h9A3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY model: records every rising MDC edge and answers reads.
  always @(posedge mdc) begin
    if (nrise > 0 && ($realtime - last_rise) < min_period) min_period = $realtime - last_rise;
    last_rise = $realtime;
    if (nrise < 128) rec[nrise] = mdio_oe ? int'(mdio_o) : 2;
    nrise++;
    if (nrise == 49 && rec[33] == 1 && rec[34] == 1 && rec[35] == 0 &&
        rec[36] == 1 && rec[37] == 1 && rec[38] == 0) begin
      logic [4:0] p, r;
      for (int j = 0; j < 5; j++) begin
        p[4-j] = rec[39+j][0];
        r[4-j] = rec[44+j][0];
      end
      rd_val = phy_val(p, r);
      rd_on  = 1'b1;
    end
    if (rd_on && nrise >= 49 && nrise <= 67) begin
      int k;
      k = nrise - 49;
      if (k == 0)       mdio_i = 1'b1;
      else if (k == 1)  mdio_i = 1'b0;
      else if (k <= 17) mdio_i = rd_val[17-k];
      else              mdio_i = 1'b1;
    end else begin
      mdio_i = 1'b1;
      if (nrise >= 68) rd_on = 1'b0;
    end
  end

  always @(negedge mdc) begin
    if ($realtime - last_rise < min_hi) min_hi = $realtime - last_rise;
    if ($realtime - last_rise > max_hi) max_hi = $realtime - last_rise;
  end

  // R7 watcher: outputs must hold through the high phase.
  always @(posedge mdc) begin : hold_watch
    logic v, o;
    v = mdio_o;
    o = mdio_oe;
    #190;
    if (o !== mdio_oe || (o && v !== mdio_o)) r7_bad++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic issue(input logic wr, input logic [4:0] p, input logic [RAW-1:0] r,
                       input logic [15:0] d);
    nrise = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input logic wr, output logic [15:0] got);
    got = '0;
    if (wr) begin
      while (status[31]) @(negedge clk);
    end else begin
      while (!rsp_valid) @(negedge clk);
      got = rsp_rdata;
      @(negedge clk);
    end
  endtask

  task automatic check_stream(input logic wr, input logic [4:0] p, input logic [4:0] r,
                              input logic [15:0] d);
    logic [31:0] hw;
    int hl, tl, bad;
    hw = wr ? {4'b0101, p, r, 2'b10, d} : {6'b110110, p, r, 16'h0000};
    hl = wr ? 32 : 16;
    tl = wr ? 2 : 19;
    bad = 0;
    for (int i = 0; i < 33; i++) if (rec[i] != 1) bad++;
    chk("R3 preamble bad bits", bad, 0);
    bad = 0;
    for (int i = 0; i < hl; i++) if (rec[33+i] != int'(hw[31-i])) bad++;
    chk(wr ? "R6 write frame bad bits" : "R4 read header bad bits", bad, 0);
    bad = 0;
    for (int i = 0; i < tl; i++) if (rec[33+hl+i] != 2) bad++;
    chk(wr ? "R6 released idle bad" : "R5 released capture bad", bad, 0);
    chk("R3 rising edge count", nrise, 33 + hl + tl);
  endtask

  // {write, phy[4:0], reg[5:0], data[15:0]}
  localparam logic [27:0] VEC [0:7] = '{
    {1'b0, 5'd1,  6'd0,  16'h0000},
    {1'b0, 5'd31, 6'd31, 16'h0000},
    {1'b1, 5'd5,  6'd4,  16'h01E1},
    {1'b0, 5'd0,  6'd1,  16'h0000},
    {1'b1, 5'd31, 6'd31, 16'hFFFF},
    {1'b1, 5'd0,  6'd0,  16'h0000},
    {1'b0, 5'd10, 6'd21, 16'h0000},
    {1'b1, 5'd21, 6'd10, 16'hA55A}
  };

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mdc after reset", mdc, 0);
    chk("R1 oe after reset", mdio_oe, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 status after reset", status, 0);

    for (int v = 0; v < 8; v++) begin
      logic wr; logic [4:0] p; logic [5:0] r; logic [15:0] d;
      {wr, p, r, d} = VEC[v];
      issue(wr, p, r, d);
      chk("R9 busy during transaction", status[31], 1);
      wait_done(wr, got);
      check_stream(wr, p, r[4:0], d);
      if (!wr) chk("R5 read data", got, phy_val(p, r[4:0]));
      else     chk("R6 no response after write", rsp_valid, 0);
      chk("R9 idle after completion", status[31], 0);
    end
    chk("R2 min MDC period >= 400ns", (min_period >= 399.9) ? 1 : 0, 1);
    chk("R2 high phase exact", (min_hi >= 199.9 && max_hi <= 200.1) ? 1 : 0, 1);
    chk("R7 change while MDC high", r7_bad, 0);

    // R8 invalid read address
    nrise = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_phy = 5'd1; req_reg = 6'd40;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 invalid read rsp_valid", rsp_valid, 1);
    chk("R8 invalid read data", rsp_rdata, 16'hFFFF);
    repeat (50) @(negedge clk);
    chk("R8 invalid read no MDC", nrise, 0);

    // R8 invalid write address
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_reg = 6'd63; req_wdata = 16'h1234;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 invalid write idle", status[31], 0);
    chk("R8 invalid write ready", req_ready, 1);
    repeat (50) @(negedge clk);
    chk("R8 invalid write no MDC", nrise, 0);

    // R10 requests while busy are ignored
    issue(1'b0, 5'd3, 6'd7, 16'h0000);
    repeat (200) @(negedge clk);
    chk("R10 ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd9; req_reg = 6'd2; req_wdata = 16'hBEEF;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    wait_done(1'b0, got);
    chk("R10 result unaffected", got, phy_val(5'd3, 5'd7));
    check_stream(1'b0, 5'd3, 5'd7, 16'h0000);
    repeat (300) @(negedge clk);
    chk("R10 no late transaction", nrise, 68);
    chk("R10 idle afterwards", status[31], 0);

    // R11 response back-pressure, R9 status fields
    rsp_ready = 1'b0;
    issue(1'b0, 5'd2, 6'd3, 16'h0000);
    while (!rsp_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R11 rsp_valid held", rsp_valid, 1);
    chk("R11 rsp data held", rsp_rdata, phy_val(5'd2, 5'd3));
    chk("R9 busy while response pending", status[31], 1);
    chk("R9 status low half", status[15:0], phy_val(5'd2, 5'd3));
    chk("R9 status middle zero", status[30:16], 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 rsp_valid cleared", rsp_valid, 0);
    chk("R11 busy cleared", status[31], 0);
    chk("R7 change while MDC high", r7_bad, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule